// File: doc/BRIEF.md
# Paired-Page Translation Lookaside Buffer

This block translates 32-bit virtual addresses into physical addresses with a small, fully associative translation buffer. Each entry covers two neighbouring 4 KB virtual pages, an even page and an odd page, and maps each of them to its own physical frame. Each half has its own valid and dirty flags. An entry belongs to one 8-bit address-space identifier unless its global flag is set. With the global flag set, the entry matches in every address space.

Each cycle the caller may present a lookup. A lookup carries a virtual address, the current address-space identifier and a read/write flag. One clock later the block returns four things:
- a result code (hit, miss, invalid or modify fault),
- the physical address,
- the read and write permissions,
- the index of the matching entry, which serves as a probe.

Software loads an entry through a write port that names the target index. All entry storage is cleared at reset, so every lookup misses until entries are written.

Top module: `tlbp_top`

## Requirements
- R1: An entry matches a lookup when its stored page-pair number equals `lk_vaddr[31:13]` and its global flag is set or its stored identifier equals `lk_asid`. An entry with both halves invalid is empty and never matches.
- R2: `lk_vaddr[12]` selects the half of the matched entry. A value of 1 selects the odd half and 0 selects the even half.
- R3: If the selected half is not valid, the result code is 2 (invalid), for reads and for writes alike.
- R4: A read to a valid half gives code 0 (hit). A write to a valid half gives code 0 only when that half's dirty flag is set; otherwise it gives code 3 (modify fault).
- R5: On a hit, `rs_paddr` is the selected half's 20-bit frame number followed by `lk_vaddr[11:0]`. On any other code `rs_paddr` is zero.
- R6: On a hit, `rs_rperm` is 1 and `rs_wperm` equals the selected half's dirty flag. On any other code both are 0.
- R7: When no entry matches, the result code is 1 (miss).
- R8: When several entries match, the lowest index wins. `rs_match` is 1 whenever any entry matches, and `rs_index` then gives the winning index. With no match, both are 0.
- R9: Reset empties every entry, so each lookup after reset misses until an entry is written.
- R10: Results appear on the cycle after the lookup is sampled, and `rs_valid` repeats `lk_valid` from that cycle. An entry write takes effect for lookups sampled on later edges. A lookup sampled on the same edge as a write sees the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_asid | input | 8 | Current address-space identifier |
| lk_write | input | 1 | 1 for a store access, 0 for a load |
| wr_en | input | 1 | Entry write strobe |
| wr_index | input | 4 | Entry index to load |
| wr_vpn2 | input | 19 | Page-pair number to store |
| wr_asid | input | 8 | Identifier to store |
| wr_global | input | 1 | Global flag to store |
| wr_pfn_even | input | 20 | Frame number of the even half |
| wr_v_even | input | 1 | Valid flag of the even half |
| wr_d_even | input | 1 | Dirty flag of the even half |
| wr_pfn_odd | input | 20 | Frame number of the odd half |
| wr_v_odd | input | 1 | Valid flag of the odd half |
| wr_d_odd | input | 1 | Dirty flag of the odd half |
| rs_valid | output | 1 | Result valid |
| rs_code | output | 2 | 0 hit, 1 miss, 2 invalid, 3 modify fault |
| rs_paddr | output | 32 | Translated physical address |
| rs_rperm | output | 1 | Read permitted |
| rs_wperm | output | 1 | Write permitted |
| rs_match | output | 1 | Some entry matched |
| rs_index | output | 4 | Index of the winning entry |

## Verification
The bench targets the following corner cases:
- Address bit 12 picks between two halves with different frames and flags. A design that decoded the wrong bit would return the other half's frame.
- Overlapping entries mix global and identifier-tagged matches. Wrong priority would surface as a higher index or the wrong frame.
- Clean valid pages take store accesses. A missing dirty check would show up as a hit with write permission where a modify fault belongs.
- Entries are written on the same edge as a lookup to that index. A design that forwarded the write would then answer with the new contents one cycle early.
- Immediately after reset, every lookup must miss, including ones with page number and identifier zero that an uncleared entry would catch.

// File: rtl/tlbp_pkg.sv
package tlbp_pkg;
    parameter int VA_W   = 32;
    parameter int OFS_W  = 12;
    parameter int ASID_W = 8;
    parameter int PFN_W  = 20;

    localparam int VPN2_W = VA_W - OFS_W - 1;
    localparam int PA_W   = PFN_W + OFS_W;

    typedef enum logic [1:0] {
        RES_HIT     = 2'd0,
        RES_MISS    = 2'd1,
        RES_INVALID = 2'd2,
        RES_MODIFY  = 2'd3
    } res_e;

    typedef struct packed {
        logic [VPN2_W-1:0] vpn2;
        logic [ASID_W-1:0] asid;
        logic              glob;
        logic [PFN_W-1:0]  pfn_even;
        logic              v_even;
        logic              d_even;
        logic [PFN_W-1:0]  pfn_odd;
        logic              v_odd;
        logic              d_odd;
    } entry_t;
endpackage

// File: rtl/tlbp_store.sv
module tlbp_store
    import tlbp_pkg::*;
#(
    parameter int N     = 16,
    parameter int IDX_W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en_i,
    input  logic [IDX_W-1:0]     wr_idx_i,
    input  entry_t               wr_entry_i,
    output entry_t [N-1:0]       ents_o
);
    entry_t [N-1:0] ents_d, ents_q;

    always_comb begin
        ents_d = ents_q;
        if (wr_en_i && (int'(wr_idx_i) < N)) begin
            ents_d[wr_idx_i] = wr_entry_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ents_q <= '0;
        end else begin
            ents_q <= ents_d;
        end
    end

    assign ents_o = ents_q;
endmodule

// File: rtl/tlbp_match.sv
module tlbp_match
    import tlbp_pkg::*;
#(
    parameter int N     = 16,
    parameter int IDX_W = 4
) (
    input  entry_t [N-1:0]      ents_i,
    input  logic [VPN2_W-1:0]   vpn2_i,
    input  logic [ASID_W-1:0]   asid_i,
    output logic                any_o,
    output logic [IDX_W-1:0]    idx_o,
    output entry_t              sel_o
);
    logic [N-1:0] hit_vec;

    for (genvar g = 0; g < N; g++) begin : g_cmp
        logic occupied;
        logic tag_eq;
        logic space_ok;
        assign occupied = ents_i[g].v_even | ents_i[g].v_odd;
        assign tag_eq   = (ents_i[g].vpn2 == vpn2_i);
        assign space_ok = ents_i[g].glob | (ents_i[g].asid == asid_i);
        assign hit_vec[g] = occupied & tag_eq & space_ok;
    end

    always_comb begin
        any_o = 1'b0;
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                any_o = 1'b1;
                idx_o = IDX_W'(i);
            end
        end
    end

    assign sel_o = ents_i[idx_o];
endmodule

// File: rtl/tlbp_resolve.sv
module tlbp_resolve
    import tlbp_pkg::*;
(
    input  logic              any_i,
    input  entry_t            sel_i,
    input  logic              odd_i,
    input  logic [OFS_W-1:0]  ofs_i,
    input  logic              write_i,
    output res_e              code_o,
    output logic [PA_W-1:0]   paddr_o,
    output logic              rperm_o,
    output logic              wperm_o
);
    logic [PFN_W-1:0] pfn;
    logic             half_v;
    logic             half_d;

    always_comb begin
        pfn    = odd_i ? sel_i.pfn_odd : sel_i.pfn_even;
        half_v = odd_i ? sel_i.v_odd   : sel_i.v_even;
        half_d = odd_i ? sel_i.d_odd   : sel_i.d_even;

        if (!any_i) begin
            code_o = RES_MISS;
        end else if (!half_v) begin
            code_o = RES_INVALID;
        end else if (write_i && !half_d) begin
            code_o = RES_MODIFY;
        end else begin
            code_o = RES_HIT;
        end

        if (code_o == RES_HIT) begin
            paddr_o = {pfn, ofs_i};
            rperm_o = 1'b1;
            wperm_o = half_d;
        end else begin
            paddr_o = '0;
            rperm_o = 1'b0;
            wperm_o = 1'b0;
        end
    end
endmodule

// File: rtl/tlbp_top.sv
module tlbp_top
    import tlbp_pkg::*;
#(
    parameter int NUM_ENTRIES = 16,
    localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  lk_valid,
    input  logic [VA_W-1:0]       lk_vaddr,
    input  logic [ASID_W-1:0]     lk_asid,
    input  logic                  lk_write,
    input  logic                  wr_en,
    input  logic [IDX_W-1:0]      wr_index,
    input  logic [VPN2_W-1:0]     wr_vpn2,
    input  logic [ASID_W-1:0]     wr_asid,
    input  logic                  wr_global,
    input  logic [PFN_W-1:0]      wr_pfn_even,
    input  logic                  wr_v_even,
    input  logic                  wr_d_even,
    input  logic [PFN_W-1:0]      wr_pfn_odd,
    input  logic                  wr_v_odd,
    input  logic                  wr_d_odd,
    output logic                  rs_valid,
    output logic [1:0]            rs_code,
    output logic [PA_W-1:0]       rs_paddr,
    output logic                  rs_rperm,
    output logic                  rs_wperm,
    output logic                  rs_match,
    output logic [IDX_W-1:0]      rs_index
);
    typedef struct packed {
        logic             valid;
        res_e             code;
        logic [PA_W-1:0]  paddr;
        logic             rperm;
        logic             wperm;
        logic             match;
        logic [IDX_W-1:0] index;
    } out_t;

    entry_t                    wr_entry;
    entry_t [NUM_ENTRIES-1:0]  ents;
    logic                      m_any;
    logic [IDX_W-1:0]          m_idx;
    entry_t                    m_sel;
    res_e                      r_code;
    logic [PA_W-1:0]           r_paddr;
    logic                      r_rperm;
    logic                      r_wperm;
    out_t                      out_d, out_q;

    always_comb begin
        wr_entry          = '0;
        wr_entry.vpn2     = wr_vpn2;
        wr_entry.asid     = wr_asid;
        wr_entry.glob     = wr_global;
        wr_entry.pfn_even = wr_pfn_even;
        wr_entry.v_even   = wr_v_even;
        wr_entry.d_even   = wr_d_even;
        wr_entry.pfn_odd  = wr_pfn_odd;
        wr_entry.v_odd    = wr_v_odd;
        wr_entry.d_odd    = wr_d_odd;
    end

    tlbp_store #(.N(NUM_ENTRIES), .IDX_W(IDX_W)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (wr_en),
        .wr_idx_i   (wr_index),
        .wr_entry_i (wr_entry),
        .ents_o     (ents)
    );

    tlbp_match #(.N(NUM_ENTRIES), .IDX_W(IDX_W)) u_match (
        .ents_i (ents),
        .vpn2_i (lk_vaddr[VA_W-1:OFS_W+1]),
        .asid_i (lk_asid),
        .any_o  (m_any),
        .idx_o  (m_idx),
        .sel_o  (m_sel)
    );

    tlbp_resolve u_resolve (
        .any_i   (m_any),
        .sel_i   (m_sel),
        .odd_i   (lk_vaddr[OFS_W]),
        .ofs_i   (lk_vaddr[OFS_W-1:0]),
        .write_i (lk_write),
        .code_o  (r_code),
        .paddr_o (r_paddr),
        .rperm_o (r_rperm),
        .wperm_o (r_wperm)
    );

    always_comb begin
        out_d       = out_q;
        out_d.valid = lk_valid;
        if (lk_valid) begin
            out_d.code  = r_code;
            out_d.paddr = r_paddr;
            out_d.rperm = r_rperm;
            out_d.wperm = r_wperm;
            out_d.match = m_any;
            out_d.index = m_any ? m_idx : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q      <= '0;
            out_q.code <= RES_MISS;
        end else begin
            out_q <= out_d;
        end
    end

    assign rs_valid = out_q.valid;
    assign rs_code  = out_q.code;
    assign rs_paddr = out_q.paddr;
    assign rs_rperm = out_q.rperm;
    assign rs_wperm = out_q.wperm;
    assign rs_match = out_q.match;
    assign rs_index = out_q.index;
endmodule

// File: rtl/tlbp_chk.sv
module tlbp_chk #(
    parameter int PA_W = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            lk_valid,
    input logic            lk_write,
    input logic            rs_valid,
    input logic [1:0]      rs_code,
    input logic [PA_W-1:0] rs_paddr,
    input logic            rs_rperm,
    input logic            rs_wperm,
    input logic            rs_match
);
    // R10
    req_to_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rs_valid);

    // R10
    idle_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !rs_valid);

    // R4
    read_no_modify_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && !lk_write) |=> (rs_code != 2'd3));

    // R5
    nohit_zero_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rs_valid && rs_code != 2'd0) |-> (rs_paddr == '0));

    // R6
    hit_read_perm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rs_valid && rs_code == 2'd0) |-> rs_rperm);

    // R6
    fault_no_perm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rs_valid && rs_code != 2'd0) |-> (!rs_rperm && !rs_wperm));

    // R8
    miss_no_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rs_valid |-> (rs_match == (rs_code != 2'd1)));
endmodule

bind tlbp_top tlbp_chk #(.PA_W(tlbp_pkg::PA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .lk_valid (lk_valid),
    .lk_write (lk_write),
    .rs_valid (rs_valid),
    .rs_code  (rs_code),
    .rs_paddr (rs_paddr),
    .rs_rperm (rs_rperm),
    .rs_wperm (rs_wperm),
    .rs_match (rs_match)
);

// File: tb/tlbp_top_bench.sv
module tlbp_top_bench;
    localparam int NE = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic [7:0]  lk_asid = '0;
    logic        lk_write = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_index = '0;
    logic [18:0] wr_vpn2 = '0;
    logic [7:0]  wr_asid = '0;
    logic        wr_global = 1'b0;
    logic [19:0] wr_pfn_even = '0;
    logic        wr_v_even = 1'b0;
    logic        wr_d_even = 1'b0;
    logic [19:0] wr_pfn_odd = '0;
    logic        wr_v_odd = 1'b0;
    logic        wr_d_odd = 1'b0;
    logic        rs_valid;
    logic [1:0]  rs_code;
    logic [31:0] rs_paddr;
    logic        rs_rperm;
    logic        rs_wperm;
    logic        rs_match;
    logic [3:0]  rs_index;

    always #5 clk = ~clk;

    tlbp_top #(.NUM_ENTRIES(NE)) u_tlbp_top (.*);

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    string cur_tag = "R1";

    // behavioural model contents
    int m_vpn[NE];
    int m_asid[NE];
    int m_pfn0[NE];
    int m_pfn1[NE];
    bit m_g[NE], m_v0[NE], m_d0[NE], m_v1[NE], m_d1[NE];

    // expected result of the lookup currently in flight
    bit          e_valid = 1'b0;
    int          e_code = 1;
    logic [31:0] e_paddr = '0;
    bit          e_r = 1'b0, e_w = 1'b0, e_m = 1'b0;
    int          e_idx = 0;

    // write pending in model (presented, not yet applied)
    bit p_we = 1'b0;
    int p_idx, p_vpn, p_asid, p_pfn0, p_pfn1;
    bit p_g, p_v0, p_d0, p_v1, p_d1;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s/%s actual=%h expected=%h t=%0t", cur_tag, tag, act, exp, $time);
        end
    endtask

    function automatic string code_tag(input int c);
        case (c)
            0: return "R4";
            1: return "R7";
            2: return "R3";
            default: return "R4";
        endcase
    endfunction

    task automatic model_lookup();
        int found = -1;
        bit odd, v, d;
        int pfn;
        for (int i = 0; i < NE; i++) begin
            if (found < 0 && (m_v0[i] || m_v1[i]) && m_vpn[i] == int'(lk_vaddr[31:13])
                && (m_g[i] || m_asid[i] == int'(lk_asid))) found = i;
        end
        e_valid = lk_valid;
        e_r = 0; e_w = 0; e_paddr = '0; e_m = 0; e_idx = 0;
        if (found < 0) begin
            e_code = 1;
        end else begin
            e_m = 1; e_idx = found;
            odd = lk_vaddr[12];
            v   = odd ? m_v1[found] : m_v0[found];
            d   = odd ? m_d1[found] : m_d0[found];
            pfn = odd ? m_pfn1[found] : m_pfn0[found];
            if (!v) e_code = 2;
            else if (lk_write && !d) e_code = 3;
            else begin
                e_code = 0;
                e_paddr = {pfn[19:0], lk_vaddr[11:0]};
                e_r = 1; e_w = d;
            end
        end
    endtask

    // One cycle: check the previous result, commit the pending write to the
    // model, then present the staged inputs and predict their result.
    task automatic tick(input bit lv, input logic [31:0] va, input int asid, input bit lw,
                        input bit we, input int idx, input int vpn, input int wasid,
                        input bit g, input int pf0, input bit v0, input bit d0,
                        input int pf1, input bit v1, input bit d1);
        @(negedge clk);
        chk("R10", 32'(rs_valid), 32'(e_valid));
        if (e_valid) begin
            chk(code_tag(e_code), 32'(rs_code), 32'(e_code));
            chk("R5", rs_paddr, e_paddr);
            chk("R6", {30'd0, rs_rperm, rs_wperm}, {30'd0, e_r, e_w});
            chk("R8", {27'd0, rs_match, rs_index}, {27'd0, e_m, 4'(e_idx)});
        end
        if (p_we) begin
            m_vpn[p_idx] = p_vpn; m_asid[p_idx] = p_asid; m_g[p_idx] = p_g;
            m_pfn0[p_idx] = p_pfn0; m_v0[p_idx] = p_v0; m_d0[p_idx] = p_d0;
            m_pfn1[p_idx] = p_pfn1; m_v1[p_idx] = p_v1; m_d1[p_idx] = p_d1;
        end
        lk_valid = lv; lk_vaddr = va; lk_asid = 8'(asid); lk_write = lw;
        wr_en = we; wr_index = 4'(idx); wr_vpn2 = 19'(vpn); wr_asid = 8'(wasid);
        wr_global = g; wr_pfn_even = 20'(pf0); wr_v_even = v0; wr_d_even = d0;
        wr_pfn_odd = 20'(pf1); wr_v_odd = v1; wr_d_odd = d1;
        p_we = we; p_idx = idx; p_vpn = vpn; p_asid = wasid; p_g = g;
        p_pfn0 = pf0; p_v0 = v0; p_d0 = d0; p_pfn1 = pf1; p_v1 = v1; p_d1 = d1;
        model_lookup();
    endtask

    task automatic look(input int vpn, input bit odd, input int ofs, input int asid, input bit lw);
        tick(1, {19'(vpn), odd, 12'(ofs)}, asid, lw, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic put(input int idx, input int vpn, input int asid, input bit g,
                       input int pf0, input bit v0, input bit d0,
                       input int pf1, input bit v1, input bit d1);
        tick(0, 32'd0, 0, 0, 1, idx, vpn, asid, g, pf0, v0, d0, pf1, v1, d1);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        for (int i = 0; i < NE; i++) begin
            m_vpn[i] = 0; m_asid[i] = 0; m_pfn0[i] = 0; m_pfn1[i] = 0;
            m_g[i] = 0; m_v0[i] = 0; m_d0[i] = 0; m_v1[i] = 0; m_d1[i] = 0;
        end
        repeat (3) @(negedge clk);
        cur_tag = "R9";
        chk("R9", 32'(rs_valid), 32'd0);
        rst_n = 1'b1;
        // R9: all-zero page number and identifier must miss after reset
        look(0, 0, 0, 0, 0);
        look(0, 1, 12'h004, 0, 1);
        look(19'h00010, 0, 12'h123, 5, 0);

        cur_tag = "R1";
        put(0, 19'h00010, 5, 0, 20'h00111, 1, 1, 20'h00222, 1, 0);
        put(1, 19'h00020, 200, 1, 20'h00333, 0, 0, 20'h00444, 1, 1);
        put(2, 19'h00030, 9, 0, 20'h00555, 1, 0, 20'h00666, 1, 1);
        put(5, 19'h00030, 1, 1, 20'h00777, 1, 1, 20'h00888, 1, 1);
        look(19'h00010, 0, 12'hABC, 5, 0);   // identifier equal: hit even
        look(19'h00010, 0, 12'hABC, 6, 0);   // identifier differs: miss
        look(19'h00020, 1, 12'h001, 77, 0);  // global: hit odd
        look(19'h00011, 0, 12'h000, 5, 0);   // neighbouring pair: miss

        cur_tag = "R2";
        look(19'h00010, 1, 12'hFFF, 5, 0);
        look(19'h00010, 0, 12'hFFF, 5, 0);

        cur_tag = "R3";
        look(19'h00020, 0, 12'h010, 3, 0);
        look(19'h00020, 0, 12'h010, 3, 1);

        cur_tag = "R4";
        look(19'h00010, 1, 12'h020, 5, 0);   // clean read: hit
        look(19'h00010, 1, 12'h020, 5, 1);   // clean write: modify fault
        look(19'h00010, 0, 12'h020, 5, 1);   // dirty write: hit, writable

        cur_tag = "R8";
        look(19'h00030, 0, 12'h100, 9, 1);   // entry 2 wins, clean: modify
        look(19'h00030, 1, 12'h100, 9, 1);   // entry 2 odd, dirty: hit
        look(19'h00030, 0, 12'h100, 4, 1);   // only entry 5

        cur_tag = "R10";
        // write and lookup of the same entry on one edge: old contents seen
        tick(1, {19'h00040, 1'b0, 12'h050}, 2, 0, 1, 3, 19'h00040, 2, 0,
             20'h0ABCD, 1, 1, 20'h0DCBA, 0, 0);
        look(19'h00040, 0, 12'h050, 2, 0);
        look(19'h00040, 1, 12'h050, 2, 0);
        tick(0, 32'd0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);

        cur_tag = "R1";
        for (int n = 0; n < 4000; n++) begin
            int vsel = $urandom % 5;
            int asel = $urandom % 4;
            tick(($urandom % 4) != 0, {19'(19'h00010 + 16 * vsel), 1'($urandom),
                 12'($urandom)}, 3 + 2 * asel, 1'($urandom),
                 ($urandom % 6) == 0, $urandom % NE, 19'h00010 + 16 * ($urandom % 5),
                 3 + 2 * ($urandom % 4), ($urandom % 5) == 0,
                 $urandom % 1048576, 1'($urandom), 1'($urandom),
                 $urandom % 1048576, 1'($urandom), 1'($urandom));
        end
        tick(0, 32'd0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end
endmodule